// File: doc/BRIEF.md
# DMA Controller Register File and Interrupt Unit

This block is the control and status register file of a multi-channel DMA controller with up to eight channels. It stores each channel's source address, destination address, linked-list pointer, control word and configuration word, plus a global configuration word and a sync word. It keeps one raw terminal-count flag and one raw error flag per channel, and it drives a single level interrupt. The transfer engine and the channel arbiter are outside this block. They raise flags by pulsing `tc_set` and `err_set`, and they read each channel's enable bit from `ch_enable`.

The mask for each interrupt flag is not held in a register of its own. The terminal-count mask of a channel is bit 15 of that channel's configuration word, and the error mask is bit 14. Software can read the flags raw, masked, or as a combined masked view. It clears flags by writing ones to the clear registers.

The bus is a 32-bit register port with a byte address. A small state machine has two states, `BUS_IDLE` and `BUS_RESP`. In `BUS_IDLE`, `bus_ready` is high. A write takes effect at the edge where it is accepted, and the machine stays in `BUS_IDLE`. An accepted read captures its data and takes the transition IDLE→RESP. In `BUS_RESP`, `bus_rvalid` is high and `bus_ready` is low. The transition RESP→IDLE always follows one cycle later.

Top module: `dmac_csr`

## Requirements
- R1: `irq` is high exactly when some channel has (terminal-count flag AND terminal-count mask) or (error flag AND error mask) set.
- R2: The terminal-count mask of channel c is bit 15 of its configuration word, and the error mask is bit 14. With both mask bits clear, a raised flag does not assert `irq`.
- R3: A write to 0x08 clears each terminal-count flag whose data bit is 1, and a write to 0x10 does the same for error flags. Flags written with 0 keep their value.
- R4: When a set pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R5: Status reads, with channel c on data bit c: 0x00 returns the per-channel OR of the masked terminal-count and masked error flags; 0x04 returns the masked terminal-count flags; 0x0C returns the masked error flags; 0x14 returns the raw terminal-count flags; 0x18 returns the raw error flags.
- R6: The channel window spans 0x100–0x1FF, with the channel index in address bits 7:5. Window offsets 0x0, 0x4, 0x8, 0xC and 0x10 hold source, destination, link pointer, control and configuration, and each reads back its last written value.
- R7: An undefined offset, or a channel index at or above `NUM_CH`, reads as zero, and writes to it change no state.
- R8: Reads of 0xFE0–0xFFC return one identification byte in bits 7:0: 0x80, 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1 in address order. A build with other than eight channels returns 0x81 first.
- R9: Bit c of register 0x1C and of `ch_enable` equals bit 0 of channel c's configuration word.
- R10: The global configuration register (0x30) and the sync register (0x34) read back their last written 32-bit values.
- R11: Offsets 0x20, 0x24, 0x28 and 0x2C read as zero, and writes to them change no state.
- R12: An accepted read returns its data with `bus_rvalid` high in the next cycle only. `bus_ready` is low in that cycle, and no request is accepted then.
- R13: After reset, every register and flag is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted this cycle when high |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| tc_set | input | NUM_CH | Terminal-count flag set pulses, one per channel |
| err_set | input | NUM_CH | Error flag set pulses, one per channel |
| ch_enable | output | NUM_CH | Enable bit of each channel's configuration word |
| irq | output | 1 | Level interrupt |

## Verification
The embedded assertions check several rules on every cycle:
- a set pulse always leaves its flag set;
- a flag only falls when a clear bit targets it;
- `irq` stays low while every mask bit is clear;
- a channel's configuration word does not change without a bus write;
- read responses last one cycle and block acceptance.

The address decode can only be shown by the bench's scenarios. These include every register offset, the identification bytes, the soft-request and undefined holes, and the mask-bit positions. A behavioural reference model runs alongside the design and compares `irq`, `ch_enable`, the handshake and every returned read word on each clock, during both directed and randomized traffic.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    // Word indices (addr[7:2]) inside the global region
    localparam logic [5:0] W_STAT    = 6'h00;
    localparam logic [5:0] W_TCSTAT  = 6'h01;
    localparam logic [5:0] W_TCCLR   = 6'h02;
    localparam logic [5:0] W_ERRSTAT = 6'h03;
    localparam logic [5:0] W_ERRCLR  = 6'h04;
    localparam logic [5:0] W_TCRAW   = 6'h05;
    localparam logic [5:0] W_ERRRAW  = 6'h06;
    localparam logic [5:0] W_ENMAP   = 6'h07;
    localparam logic [5:0] W_GCFG    = 6'h0C;
    localparam logic [5:0] W_SYNC    = 6'h0D;

    // Configuration word bit positions
    localparam int CFG_TCM_BIT = 15;
    localparam int CFG_ERM_BIT = 14;
    localparam int CFG_EN_BIT  = 0;

    function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = (nch == 8) ? 8'h80 : 8'h81;
            3'd1: b = 8'h10;
            3'd2: b = 8'h04;
            3'd3: b = 8'h0A;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/dmac_bus_fsm.sv
module dmac_bus_fsm
    import dmac_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] rd_value,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wr_fire
);
    bus_state_e state_q, state_d;
    logic       rd_fire;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_valid && !req_write) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        bus_ready  = 1'b0;
        bus_rvalid = 1'b0;
        unique case (state_q)
            BUS_IDLE: bus_ready  = 1'b1;
            BUS_RESP: bus_rvalid = 1'b1;
        endcase
        wr_fire = bus_ready && req_valid && req_write;
        rd_fire = bus_ready && req_valid && !req_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bus_rdata <= '0;
        else if (rd_fire) bus_rdata <= rd_value;
    end

    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid); // R12
    AST_RESP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> !bus_ready); // R12
endmodule

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank
    import dmac_csr_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] chan_rdata,
    output logic [NUM_CH-1:0] ch_en,
    output logic [NUM_CH-1:0] tc_mask,
    output logic [NUM_CH-1:0] err_mask
);
    localparam int IDX_W = 3;
    localparam int SUB_W = 3;

    logic [DATA_W-1:0] src_q  [NUM_CH];
    logic [DATA_W-1:0] dst_q  [NUM_CH];
    logic [DATA_W-1:0] lli_q  [NUM_CH];
    logic [DATA_W-1:0] ctl_q  [NUM_CH];
    logic [DATA_W-1:0] cfg_q  [NUM_CH];

    logic             win_hit;
    logic [IDX_W-1:0] idx;
    logic [SUB_W-1:0] sub;

    assign win_hit = (addr[ADDR_W-1:8] == 4'h1);
    assign idx     = addr[7:5];
    assign sub     = addr[4:2];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = wr_fire && win_hit && (idx == IDX_W'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_q[c] <= '0;
                dst_q[c] <= '0;
                lli_q[c] <= '0;
                ctl_q[c] <= '0;
                cfg_q[c] <= '0;
            end else if (sel) begin
                case (sub)
                    3'd0: src_q[c] <= wdata;
                    3'd1: dst_q[c] <= wdata;
                    3'd2: lli_q[c] <= wdata;
                    3'd3: ctl_q[c] <= wdata;
                    3'd4: cfg_q[c] <= wdata;
                    default: ;
                endcase
            end
        end

        assign ch_en[c]    = cfg_q[c][CFG_EN_BIT];
        assign tc_mask[c]  = cfg_q[c][CFG_TCM_BIT];
        assign err_mask[c] = cfg_q[c][CFG_ERM_BIT];

        AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_fire |=> $stable(cfg_q[c])); // R7
    end

    always_comb begin
        chan_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (idx == IDX_W'(c)) begin
                case (sub)
                    3'd0: chan_rdata = src_q[c];
                    3'd1: chan_rdata = dst_q[c];
                    3'd2: chan_rdata = lli_q[c];
                    3'd3: chan_rdata = ctl_q[c];
                    3'd4: chan_rdata = cfg_q[c];
                    default: chan_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/dmac_irq_flags.sv
module dmac_irq_flags #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tc_set,
    input  logic [NUM_CH-1:0] err_set,
    input  logic [NUM_CH-1:0] tc_clr,
    input  logic [NUM_CH-1:0] err_clr,
    input  logic [NUM_CH-1:0] tc_mask,
    input  logic [NUM_CH-1:0] err_mask,
    output logic [NUM_CH-1:0] tc_raw,
    output logic [NUM_CH-1:0] err_raw,
    output logic              irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_raw  <= '0;
            err_raw <= '0;
        end else begin
            tc_raw  <= (tc_raw  & ~tc_clr)  | tc_set;
            err_raw <= (err_raw & ~err_clr) | err_set;
        end
    end

    assign irq = |((tc_raw & tc_mask) | (err_raw & err_mask));

    AST_TC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_set != '0) |=> ((tc_raw & $past(tc_set)) == $past(tc_set))); // R4
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != '0) |=> ((err_raw & $past(err_set)) == $past(err_set))); // R4
    AST_TC_FALL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tc_raw) & ~tc_raw & ~$past(tc_clr)) == '0); // R3
    AST_ERR_FALL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_raw) & ~err_raw & ~$past(err_clr)) == '0); // R3
endmodule

// File: rtl/dmac_csr.sv
module dmac_csr
    import dmac_csr_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] tc_set,
    input  logic [NUM_CH-1:0] err_set,
    output logic [NUM_CH-1:0] ch_enable,
    output logic              irq
);
    logic              wr_fire;
    logic [DATA_W-1:0] rd_value;
    logic [DATA_W-1:0] chan_rdata;
    logic [NUM_CH-1:0] tc_mask, err_mask, tc_raw, err_raw;
    logic [NUM_CH-1:0] tc_clr, err_clr;
    logic [DATA_W-1:0] gcfg_q, sync_q;
    logic              glob_hit;
    logic [5:0]        gword;

    assign glob_hit = (bus_addr[ADDR_W-1:8] == 4'h0);
    assign gword    = bus_addr[7:2];

    dmac_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (bus_valid),
        .req_write  (bus_write),
        .rd_value   (rd_value),
        .bus_ready  (bus_ready),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .wr_fire    (wr_fire)
    );

    dmac_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_fire    (wr_fire),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .chan_rdata (chan_rdata),
        .ch_en      (ch_enable),
        .tc_mask    (tc_mask),
        .err_mask   (err_mask)
    );

    assign tc_clr  = (wr_fire && glob_hit && gword == W_TCCLR)  ? bus_wdata[NUM_CH-1:0] : '0;
    assign err_clr = (wr_fire && glob_hit && gword == W_ERRCLR) ? bus_wdata[NUM_CH-1:0] : '0;

    dmac_irq_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc_set   (tc_set),
        .err_set  (err_set),
        .tc_clr   (tc_clr),
        .err_clr  (err_clr),
        .tc_mask  (tc_mask),
        .err_mask (err_mask),
        .tc_raw   (tc_raw),
        .err_raw  (err_raw),
        .irq      (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gcfg_q <= '0;
            sync_q <= '0;
        end else if (wr_fire && glob_hit) begin
            if (gword == W_GCFG) gcfg_q <= bus_wdata;
            if (gword == W_SYNC) sync_q <= bus_wdata;
        end
    end

    always_comb begin
        rd_value = '0;
        if (glob_hit) begin
            case (gword)
                W_STAT:    rd_value = DATA_W'((tc_raw & tc_mask) | (err_raw & err_mask));
                W_TCSTAT:  rd_value = DATA_W'(tc_raw & tc_mask);
                W_ERRSTAT: rd_value = DATA_W'(err_raw & err_mask);
                W_TCRAW:   rd_value = DATA_W'(tc_raw);
                W_ERRRAW:  rd_value = DATA_W'(err_raw);
                W_ENMAP:   rd_value = DATA_W'(ch_enable);
                W_GCFG:    rd_value = gcfg_q;
                W_SYNC:    rd_value = sync_q;
                default:   rd_value = '0;
            endcase
        end else if (bus_addr[ADDR_W-1:8] == 4'h1) begin
            rd_value = chan_rdata;
        end else if (bus_addr[ADDR_W-1:5] == 7'h7F) begin
            rd_value = DATA_W'(id_byte(bus_addr[4:2], NUM_CH));
        end
    end

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((tc_mask == '0) && (err_mask == '0)) |-> !irq); // R2
    AST_GCFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> ($stable(gcfg_q) && $stable(sync_q))); // R10
endmodule

// File: tb/dmac_csr_tb.sv
module dmac_csr_tb;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] tc_set = '0, err_set = '0, ch_enable;
    logic        irq;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    dmac_csr #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .tc_set(tc_set),
        .err_set(err_set), .ch_enable(ch_enable), .irq(irq)
    );

    // Reference model state
    logic [31:0] m_src[NCH], m_dst[NCH], m_lli[NCH], m_ctl[NCH], m_cfg[NCH];
    logic [31:0] m_gcfg, m_sync, m_rdata;
    logic [NCH-1:0] m_tc, m_err;
    bit    m_resp;
    string m_tag;

    function automatic logic [NCH-1:0] m_tcm();
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) v[c] = m_cfg[c][15];
        return v;
    endfunction
    function automatic logic [NCH-1:0] m_erm();
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) v[c] = m_cfg[c][14];
        return v;
    endfunction
    function automatic logic [NCH-1:0] m_en();
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) v[c] = m_cfg[c][0];
        return v;
    endfunction

    function automatic logic [31:0] mread(logic [11:0] a);
        int idx, sub;
        if (a < 12'h100) begin
            case (a & 12'hFFC)
                12'h000: return 32'((m_tc & m_tcm()) | (m_err & m_erm()));
                12'h004: return 32'(m_tc & m_tcm());
                12'h00C: return 32'(m_err & m_erm());
                12'h014: return 32'(m_tc);
                12'h018: return 32'(m_err);
                12'h01C: return 32'(m_en());
                12'h030: return m_gcfg;
                12'h034: return m_sync;
                default: return 32'h0;
            endcase
        end else if (a < 12'h200) begin
            idx = int'(a[7:5]); sub = int'(a[4:2]);
            if (idx >= NCH) return 32'h0;
            case (sub)
                0: return m_src[idx];
                1: return m_dst[idx];
                2: return m_lli[idx];
                3: return m_ctl[idx];
                4: return m_cfg[idx];
                default: return 32'h0;
            endcase
        end else if (a >= 12'hFE0) begin
            case (a[4:2])
                3'd0: return (NCH == 8) ? 32'h80 : 32'h81;
                3'd1: return 32'h10;
                3'd2: return 32'h04;
                3'd3: return 32'h0A;
                3'd4: return 32'h0D;
                3'd5: return 32'hF0;
                3'd6: return 32'h05;
                default: return 32'hB1;
            endcase
        end
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, step model at posedge, compare at next negedge
    task automatic step(bit v, bit w, logic [11:0] a, logic [31:0] d,
                        logic [NCH-1:0] ts, logic [NCH-1:0] es, string tag);
        bit acc;
        logic [31:0] rexp;
        logic [NCH-1:0] tclr, eclr;
        int idx, sub;
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        tc_set = ts; err_set = es;
        acc  = v && !m_resp;
        rexp = mread(a);
        tclr = '0; eclr = '0;
        @(posedge clk);
        if (m_resp) m_resp = 1'b0;
        else if (acc && !w) begin m_resp = 1'b1; m_rdata = rexp; m_tag = tag; end
        else if (acc && w) begin
            if (a < 12'h100) begin
                case (a & 12'hFFC)
                    12'h008: tclr = d[NCH-1:0];
                    12'h010: eclr = d[NCH-1:0];
                    12'h030: m_gcfg = d;
                    12'h034: m_sync = d;
                    default: ;
                endcase
            end else if (a < 12'h200) begin
                idx = int'(a[7:5]); sub = int'(a[4:2]);
                if (idx < NCH) begin
                    case (sub)
                        0: m_src[idx] = d;
                        1: m_dst[idx] = d;
                        2: m_lli[idx] = d;
                        3: m_ctl[idx] = d;
                        4: m_cfg[idx] = d;
                        default: ;
                    endcase
                end
            end
        end
        m_tc  = (m_tc  & ~tclr) | ts;
        m_err = (m_err & ~eclr) | es;
        @(negedge clk);
        check("R1 irq", 32'(irq), 32'(|((m_tc & m_tcm()) | (m_err & m_erm()))));
        check("R9 ch_enable", 32'(ch_enable), 32'(m_en()));
        check("R12 ready", 32'(bus_ready), 32'(!m_resp));
        check("R12 rvalid", 32'(bus_rvalid), 32'(m_resp));
        if (m_resp) check(m_tag, bus_rdata, m_rdata);
    endtask

    task automatic idle(int n = 1);
        for (int i = 0; i < n; i++) step(0, 0, 12'h0, 32'h0, '0, '0, "idle");
    endtask
    task automatic wr(logic [11:0] a, logic [31:0] d);
        step(1, 1, a, d, '0, '0, "wr");
    endtask
    task automatic rd(logic [11:0] a, string tag);
        step(1, 0, a, 32'h0, '0, '0, tag);
        idle(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R12 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_src[c] = '0; m_dst[c] = '0; m_lli[c] = '0; m_ctl[c] = '0; m_cfg[c] = '0;
        end
        m_gcfg = '0; m_sync = '0; m_rdata = '0; m_tc = '0; m_err = '0; m_resp = 0; m_tag = "";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R13: reset state
        for (int a = 0; a < 'h40; a += 4) rd(12'(a), "R13 reset global");
        rd(12'h110, "R13 reset ch0 cfg");

        // R6: channel windows read back
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 4; s++)
                wr(12'(12'h100 + c * 32 + s * 4), 32'hA000_0000 + 32'(c * 16 + s));
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 4; s++)
                rd(12'(12'h100 + c * 32 + s * 4), "R6 window readback");

        // R9: enable bits
        wr(12'h110, 32'h0000_0001);
        wr(12'h170, 32'h0000_0001);
        rd(12'h01C, "R9 enabled map");
        rd(12'h170, "R6 cfg readback");

        // R2/R5: flags raised with masks off keep irq low
        step(0, 0, 12'h0, 32'h0, 8'h28, 8'h81, "set");
        rd(12'h014, "R5 raw tc");
        rd(12'h018, "R5 raw err");
        rd(12'h004, "R5 masked tc zero");
        rd(12'h000, "R2 combined masks off");

        // R2: tc mask bit 15 on channel 3, err mask bit 14 on channel 7
        wr(12'h170, 32'h0000_8001);
        rd(12'h004, "R2 tc mask bit15");
        wr(12'h1F0, 32'h0000_4000);
        rd(12'h00C, "R2 err mask bit14");
        rd(12'h000, "R5 combined");

        // R3: partial W1C
        wr(12'h008, 32'h0000_0020);
        rd(12'h014, "R3 tc partial clear");
        wr(12'h010, 32'h0000_0080);
        rd(12'h018, "R3 err partial clear");
        wr(12'h008, 32'h0000_0008);
        rd(12'h000, "R1 irq after clear");

        // R4: set and clear same cycle
        step(1, 1, 12'h008, 32'h0000_0004, 8'h04, 8'h00, "wr");
        rd(12'h014, "R4 tc set wins");
        step(1, 1, 12'h010, 32'h0000_0002, 8'h00, 8'h02, "wr");
        rd(12'h018, "R4 err set wins");

        // R8: identification bytes
        for (int i = 0; i < 8; i++) rd(12'(12'hFE0 + i * 4), "R8 id byte");

        // R10: global config and sync
        wr(12'h030, 32'hDEAD_BEEF);
        wr(12'h034, 32'h0000_5A5A);
        rd(12'h030, "R10 gcfg");
        rd(12'h034, "R10 sync");

        // R11: soft request holes
        for (int a = 'h20; a <= 'h2C; a += 4) begin
            wr(12'(a), 32'hFFFF_FFFF);
            rd(12'(a), "R11 soft req zero");
        end
        rd(12'h014, "R11 flags untouched");

        // R7: undefined offsets
        wr(12'h114, 32'h1234_5678);
        wr(12'h040, 32'h1234_5678);
        wr(12'h200, 32'h1234_5678);
        rd(12'h114, "R7 window hole");
        rd(12'h040, "R7 global hole");
        rd(12'h200, "R7 unmapped");
        rd(12'h110, "R7 neighbour kept");
        rd(12'h030, "R7 gcfg kept");

        // R12: request held across the response cycle
        step(1, 0, 12'h030, 32'h0, '0, '0, "R12 back to back");
        step(1, 0, 12'h034, 32'h0, '0, '0, "R12 back to back");
        step(1, 0, 12'h034, 32'h0, '0, '0, "R12 back to back");
        idle(2);

        // Mixed traffic
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            int pick;
            pick = int'($urandom % 6);
            case (pick)
                0: a = 12'(($urandom % 16) * 4);
                1: a = 12'(12'h100 + ($urandom % 8) * 32 + ($urandom % 8) * 4);
                2: a = 12'h008;
                3: a = 12'h010;
                4: a = 12'(12'hFE0 + ($urandom % 8) * 4);
                default: a = 12'h110 + 12'(($urandom % 8) * 32);
            endcase
            step(bit'($urandom % 3 != 0), bit'($urandom % 2), a, $urandom,
                 ($urandom % 4 == 0) ? NCH'($urandom) : '0,
                 ($urandom % 5 == 0) ? NCH'($urandom) : '0, "R5 mixed read");
        end
        idle(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule